// File: doc/BRIEF.md
# Show-Ahead Synchronous FIFO with Registered-Read Bypass

This block is a single-clock first-in first-out buffer. Its storage array is read through a registered port, so it can map onto block RAM, yet the read data port always shows the oldest held word in the same cycle the word becomes the head. This is show-ahead behaviour: a consumer looks at `rd_data` and pulses `rd_en` to pop it, and there is no read latency to account for.

To get show-ahead output from a registered read, the array is addressed with the look-ahead read pointer. That pointer already points one word further on whenever a pop is accepted in the current cycle. A word written in cycle N cannot come out of the array's registered read in cycle N+1, so a second register captures the write bus every cycle. A registered select flag then routes that captured word to the output when the write address matched the look-ahead read address. This case is most visible when the buffer leaves the empty state.

A build parameter chooses between the registered-read-with-bypass style and a plain combinational read of the array at the current read pointer. Both styles present identical port behaviour.

Top module: `showahead_fifo`

## Requirements
- R1: A synchronous active-high reset empties the buffer: after a clock edge with `rst` high, `empty` is 1 and `full` is 0.
- R2: A push is taken only when `wr_en` is high and `full` is low. A push attempted while full leaves the stored words and their order unchanged.
- R3: A pop is taken only when `rd_en` is high and `empty` is low. A pop attempted while empty changes nothing and `empty` stays 1.
- R4: While `empty` is low, `rd_data` equals the oldest stored word. It stays unchanged across a cycle without an accepted pop.
- R5: A word pushed into an empty buffer appears on `rd_data` one cycle after the push edge, with `empty` low. It can be popped in that very cycle.
- R6: When a push and a pop are both accepted in the same cycle, occupancy is unchanged and `full` and `empty` keep their values. With one word held, the pushed word becomes the new head on the next cycle.
- R7: `full` is 1 exactly when `DEPTH` words are held, and `empty` is 1 exactly when none are held. The two are never both 1.
- R8: Word order is preserved as the write and read positions wrap past the end of the array.
- R9: The combinational-read build (`RD_STYLE` = `RD_COMB`, encoding 0) and the registered-read build (`RD_REG`, encoding 1) give cycle-identical `rd_data`, `full` and `empty` for the same stimulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Push request |
| wr_data | input | DATA_W | Word to push |
| full | output | 1 | Buffer holds DEPTH words |
| rd_en | input | 1 | Pop request |
| rd_data | output | DATA_W | Oldest stored word (valid while empty is low) |
| empty | output | 1 | Buffer holds no words |

## Verification
The bench concentrates on a push into an empty buffer followed at once by a pop, and on a push paired with a pop while one word is held. In both cases a design without the bypass would show the stale array contents at that address instead of the new word. It also drives pushes against a full buffer and pops against an empty one. A design that ignored the flags there would either overwrite the head or corrupt the occupancy, and it would later return words out of order or report the wrong flag. Long random traffic over a small depth forces many pointer wraps, and the combinational-read build is run beside the registered one so that any divergence between the two shows up directly.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

    // Read style of the storage array.
    typedef enum logic {
        RD_COMB = 1'b0,
        RD_REG  = 1'b1
    } rd_style_e;

    // Accepted transfers in the current cycle.
    typedef struct packed {
        logic push_ok;
        logic pop_ok;
    } xfer_t;

    // Advance a position by one, wrapping at depth.
    function automatic int unsigned wrap_inc(input int unsigned pos,
                                             input int unsigned depth);
        return (pos + 1 == depth) ? 0 : pos + 1;
    endfunction

endpackage

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl
    import sfifo_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    output xfer_t         xfer,
    output logic [AW-1:0] wr_pos,
    output logic [AW-1:0] rd_pos,
    output logic [AW-1:0] rd_pos_nxt,
    output logic          full,
    output logic          empty
);

    logic [CW-1:0] occ_q;
    logic [AW-1:0] wr_pos_q;
    logic [AW-1:0] rd_pos_q;
    logic [AW-1:0] wr_pos_nxt;

    assign full  = (occ_q == CW'(DEPTH));
    assign empty = (occ_q == '0);

    always_comb begin
        xfer.push_ok = wr_en && !full;
        xfer.pop_ok  = rd_en && !empty;
    end

    always_comb begin
        wr_pos_nxt = wr_pos_q;
        rd_pos_nxt = rd_pos_q;
        if (xfer.push_ok) wr_pos_nxt = AW'(wrap_inc(int'(wr_pos_q), DEPTH));
        if (xfer.pop_ok)  rd_pos_nxt = AW'(wrap_inc(int'(rd_pos_q), DEPTH));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            occ_q    <= '0;
            wr_pos_q <= '0;
            rd_pos_q <= '0;
        end else begin
            wr_pos_q <= wr_pos_nxt;
            rd_pos_q <= rd_pos_nxt;
            unique case (xfer)
                2'b10:   occ_q <= occ_q + 1'b1;
                2'b01:   occ_q <= occ_q - 1'b1;
                default: occ_q <= occ_q;
            endcase
        end
    end

    assign wr_pos = wr_pos_q;
    assign rd_pos = rd_pos_q;

endmodule

// File: rtl/sfifo_store.sv
module sfifo_store
    import sfifo_pkg::*;
#(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned DEPTH    = 16,
    parameter rd_style_e   RD_STYLE = RD_REG,
    localparam int unsigned AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    generate
        if (RD_STYLE == RD_REG) begin : g_reg_rd
            logic [DATA_W-1:0] rd_q;
            // Read-before-write: a word written this edge is not seen here.
            always_ff @(posedge clk) begin
                rd_q <= cells[raddr];
            end
            assign rdata = rd_q;
        end else begin : g_comb_rd
            assign rdata = cells[raddr];
        end
    endgenerate

endmodule

// File: rtl/sfifo_bypass.sv
module sfifo_bypass #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned AW     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_ok,
    input  logic [AW-1:0]     wr_pos,
    input  logic [AW-1:0]     rd_pos_nxt,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] array_q,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] hold_q;
    logic              pick_q;

    // Capture the write bus unconditionally; cheap and needs no enable.
    always_ff @(posedge clk) begin
        hold_q <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) pick_q <= 1'b0;
        else     pick_q <= push_ok && (wr_pos == rd_pos_nxt);
    end

    assign rd_data = pick_q ? hold_q : array_q;

endmodule

// File: rtl/showahead_fifo.sv
module showahead_fifo
    import sfifo_pkg::*;
#(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned DEPTH    = 16,
    parameter rd_style_e   RD_STYLE = RD_REG,
    localparam int unsigned AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              full,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty
);

    xfer_t             xfer;
    logic [AW-1:0]     wr_pos;
    logic [AW-1:0]     rd_pos;
    logic [AW-1:0]     rd_pos_nxt;
    logic [AW-1:0]     rd_addr;
    logic [DATA_W-1:0] array_q;

    sfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .xfer       (xfer),
        .wr_pos     (wr_pos),
        .rd_pos     (rd_pos),
        .rd_pos_nxt (rd_pos_nxt),
        .full       (full),
        .empty      (empty)
    );

    // Registered read looks ahead; combinational read uses the present head.
    assign rd_addr = (RD_STYLE == RD_REG) ? rd_pos_nxt : rd_pos;

    sfifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .RD_STYLE(RD_STYLE)) u_store (
        .clk   (clk),
        .we    (xfer.push_ok),
        .waddr (wr_pos),
        .wdata (wr_data),
        .raddr (rd_addr),
        .rdata (array_q)
    );

    generate
        if (RD_STYLE == RD_REG) begin : g_bypass
            sfifo_bypass #(.DATA_W(DATA_W), .AW(AW)) u_bypass (
                .clk        (clk),
                .rst        (rst),
                .push_ok    (xfer.push_ok),
                .wr_pos     (wr_pos),
                .rd_pos_nxt (rd_pos_nxt),
                .wr_data    (wr_data),
                .array_q    (array_q),
                .rd_data    (rd_data)
            );
        end else begin : g_direct
            assign rd_data = array_q;
        end
    endgenerate

endmodule

// File: rtl/showahead_fifo_chk.sv
module showahead_fifo_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic              full,
    input logic              empty,
    input logic [DATA_W-1:0] rd_data
);

    assert_after_reset_R1: assert property (@(posedge clk)
        rst |=> empty && !full);

    assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
        full && !rd_en |=> full);

    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (rst)
        empty && !wr_en |=> empty);

    assert_leave_empty_R5: assert property (@(posedge clk) disable iff (rst)
        empty && wr_en |=> !empty);

    assert_head_holds_R4: assert property (@(posedge clk) disable iff (rst)
        !empty && !rd_en |=> $stable(rd_data));

    assert_pair_keeps_flags_R6: assert property (@(posedge clk) disable iff (rst)
        wr_en && rd_en && !full && !empty |=> $stable(full) && $stable(empty));

endmodule

bind showahead_fifo showahead_fifo_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .full    (full),
    .empty   (empty),
    .rd_data (rd_data)
);

// File: tb/showahead_fifo_bench.sv
module showahead_fifo_bench;
    import sfifo_pkg::*;

    localparam int unsigned DW    = 8;
    localparam int unsigned DEPTH = 4;
    localparam int NROWS = 14;

    // Row: {wr, rd, data[7:0], exp_empty, exp_full, exp_head[7:0]}
    localparam logic [19:0] VEC [NROWS] = '{
        {1'b1, 1'b0, 8'hA1, 1'b0, 1'b0, 8'hA1},  // R5 push into empty
        {1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 8'h00},  // pop back to empty
        {1'b1, 1'b1, 8'hB2, 1'b0, 1'b0, 8'hB2},  // R3 pop on empty ignored, push taken
        {1'b1, 1'b1, 8'hC3, 1'b0, 1'b0, 8'hC3},  // R6 pair with one held
        {1'b1, 1'b0, 8'hD4, 1'b0, 1'b0, 8'hC3},
        {1'b1, 1'b0, 8'hE5, 1'b0, 1'b0, 8'hC3},
        {1'b1, 1'b0, 8'hF6, 1'b0, 1'b1, 8'hC3},  // R7 full
        {1'b1, 1'b0, 8'h77, 1'b0, 1'b1, 8'hC3},  // R2 push on full ignored
        {1'b1, 1'b1, 8'h88, 1'b0, 1'b0, 8'hD4},  // R2 only the pop taken
        {1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 8'hE5},  // R8 wrapped order
        {1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 8'hF6},
        {1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 8'h00},
        {1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 8'h00},  // R3 pop on empty
        {1'b1, 1'b0, 8'h99, 1'b0, 1'b0, 8'h99}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          full_r, empty_r, full_c, empty_c;
    logic [DW-1:0] rd_data_r, rd_data_c;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [DW-1:0] q [$];

    always #5 clk = ~clk;

    showahead_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .RD_STYLE(RD_REG)) u_showahead_fifo (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .full(full_r),
        .rd_en(rd_en), .rd_data(rd_data_r), .empty(empty_r)
    );

    showahead_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .RD_STYLE(RD_COMB)) u_showahead_fifo_comb (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .full(full_c),
        .rd_en(rd_en), .rd_data(rd_data_c), .empty(empty_c)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, update the model, sample after the edge.
    task automatic step(input logic w, input logic r, input logic [DW-1:0] d);
        bit wacc, racc;
        @(negedge clk);
        wr_en = w; rd_en = r; wr_data = d;
        wacc = w && (q.size() < DEPTH);
        racc = r && (q.size() > 0);
        if (racc) void'(q.pop_front());
        if (wacc) q.push_back(d);
        @(posedge clk);
        #1;
    endtask

    task automatic model_cmp(input string req);
        chk(empty_r == (q.size() == 0), {req, " empty"}, 32'(empty_r), 32'(q.size() == 0));
        chk(full_r == (q.size() == DEPTH), {req, " full"}, 32'(full_r), 32'(q.size() == DEPTH));
        if (q.size() > 0)
            chk(rd_data_r == q[0], {req, " head"}, 32'(rd_data_r), 32'(q[0]));
        chk(empty_c == empty_r && full_c == full_r, "R9 flags", {full_c, empty_c},
            {full_r, empty_r});
        if (!empty_r)
            chk(rd_data_c == rd_data_r, "R9 data", 32'(rd_data_c), 32'(rd_data_r));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        chk(empty_r == 1'b1, "R1 empty", 32'(empty_r), 1);
        chk(full_r == 1'b0, "R1 full", 32'(full_r), 0);
        @(negedge clk);
        rst = 1'b0;

        // Table walk
        for (int i = 0; i < NROWS; i++) begin
            step(VEC[i][19], VEC[i][18], VEC[i][17:10]);
            chk(empty_r == VEC[i][9], "R7 table empty", 32'(empty_r), 32'(VEC[i][9]));
            chk(full_r == VEC[i][8], "R7 table full", 32'(full_r), 32'(VEC[i][8]));
            if (!VEC[i][9])
                chk(rd_data_r == VEC[i][7:0], "R4 table head", 32'(rd_data_r),
                    32'(VEC[i][7:0]));
            model_cmp("R8 table");
        end

        // R5: push into empty then pop at once, repeatedly
        step(1'b0, 1'b1, 8'h00);
        for (int k = 0; k < 6; k++) begin
            step(1'b1, 1'b0, 8'(8'h30 + k));
            chk(!empty_r && rd_data_r == 8'(8'h30 + k), "R5 head after push",
                32'(rd_data_r), 32'(8'h30 + k));
            step(1'b0, 1'b1, 8'h00);
            chk(empty_r == 1'b1, "R5 empty after pop", 32'(empty_r), 1);
        end

        // R6: back-to-back pairs with one word held
        step(1'b1, 1'b0, 8'h50);
        for (int k = 0; k < 6; k++) begin
            step(1'b1, 1'b1, 8'(8'h60 + k));
            chk(rd_data_r == 8'(8'h60 + k) && !empty_r, "R6 pair head",
                32'(rd_data_r), 32'(8'h60 + k));
        end
        model_cmp("R6");

        // Random traffic over several phases of bias
        for (int ph = 0; ph < 4; ph++) begin
            for (int c = 0; c < 800; c++) begin
                logic w, r;
                w = ($urandom_range(0, 3) < ph + 1);
                r = ($urandom_range(0, 3) < 4 - ph);
                step(w, r, 8'($urandom));
                model_cmp("R4 random");
            end
        end

        // R1: reset with data held
        step(1'b1, 1'b0, 8'h11);
        step(1'b1, 1'b0, 8'h12);
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
        @(posedge clk);
        #1;
        q.delete();
        chk(empty_r == 1'b1 && full_r == 1'b0, "R1 mid-run reset", {full_r, empty_r}, 2'b01);
        chk(empty_c == 1'b1 && full_c == 1'b0, "R9 mid-run reset", {full_c, empty_c}, 2'b01);
        @(negedge clk);
        rst = 1'b0;
        step(1'b1, 1'b0, 8'h7E);
        model_cmp("R1 after reset");
        step(1'b0, 1'b1, 8'h00);
        model_cmp("R3 after reset");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule